// File: doc/BRIEF.md
# CPU Packet Buffer Handshake Controller

This block coordinates two single-packet buffers that a soft processor shares with a packet routing fabric. Each direction has its own four-phase handshake, and the processor drives it through a 32-bit control word and reads it back through a 32-bit status word. Both words carry a packet length in lines in their upper half.

On the receive side, the fabric offers a filled packet and its line count on a valid/ready stream. The block accepts one packet at a time and then raises an "available" flag for the processor. The processor acknowledges by raising its release bit. The block drops the flag, and it accepts no further packet until the processor has lowered the release bit again. On the transmit side, the block reports that the buffer is free. The processor writes a line count and raises its commit bit. The block latches the count and offers it to the fabric on a valid/ready stream. It re-arms only after the commit bit has returned low.

A clear bit in the control word holds both handshakes in their idle states for as long as it is set. A mode bit selects master or slave routing, and that selection is passed through to the fabric. Software is expected to pulse the clear bit after every mode change.

Top module: `pktbuf_hs_ctrl`

## Requirements
- R1: After reset, status bit 0 (receive available) is 0 and status bit 1 (transmit free) is 1. Also after reset, `fill_ready` is 1 and `send_valid` is 0.
- R2: A fill is accepted on a clock edge where `fill_valid` and `fill_ready` are both 1. From the next cycle on, status bit 0 is 1 and status bits 31:16 hold the accepted `fill_len`.
- R3: Status bits 31:16 are 0 whenever status bit 0 is 0. While status bit 0 stays 1, bits 31:16 do not change.
- R4: If control bit 0 (receive release) is 1 while a packet is available, status bit 0 falls on the next cycle. `fill_ready` stays 0 while control bit 0 remains 1. `fill_ready` returns to 1 one cycle after control bit 0 is seen low.
- R5: `fill_ready` is 0 whenever a packet is available or a release is pending. A fill offered during that time is not taken, and it changes neither the status bits nor the stored length.
- R6: If control bit 1 (transmit commit) is 1 while the transmit buffer is free, then on the next cycle status bit 1 is 0, `send_valid` is 1, and `send_len` equals the control bits 31:16 that were sampled at that edge.
- R7: Once `send_valid` is 1, it stays 1 and `send_len` stays unchanged until a clock edge with `send_ready` at 1. The transfer completes on that edge, and `send_valid` is 0 from the next cycle on.
- R8: After a transfer completes, status bit 1 stays 0 while control bit 1 remains 1. It returns to 1 one cycle after control bit 1 is seen low.
- R9: While control bit 8 (clear) is 1, `fill_ready` is 0 and commits are ignored. From the cycle after clear is first seen, status bit 0 is 0, status bit 1 is 1, and `send_valid` is 0.
- R10: `route_master` always equals control bit 2 (1 selects master routing, 0 selects slave routing).
- R11: Once a length has been committed, changing control bits 31:16 has no effect on `send_len` for that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | 32 | Processor control word: bit 0 release, bit 1 commit, bit 2 mode, bit 8 clear, bits 31:16 transmit length |
| status_word | output | 32 | Processor status word: bit 0 available, bit 1 free, bits 31:16 receive length |
| fill_valid | input | 1 | Fabric offers a filled receive packet |
| fill_ready | output | 1 | Block can take a receive packet |
| fill_len | input | 16 | Receive packet length in lines |
| send_valid | output | 1 | Committed transmit packet offered to the fabric |
| send_ready | input | 1 | Fabric takes the transmit packet |
| send_len | output | 16 | Committed transmit length in lines |
| route_master | output | 1 | Routing mode select toward the fabric |

## Verification
The assertions check several things on every cycle. A release drops the available flag on the next edge. A receive length never changes while it is on display. A committed transmit packet holds its valid and length under back-pressure. No re-arm happens while the commit bit is still high. A clear forces both sides idle. The bench scenarios cover what the assertions cannot. They show that the exact lengths appear on each side for a sweep of length values and back-pressure delays. They also show that fills offered while the block is busy really are left untaken. Finally, they show the cycle-exact return of `fill_ready` and of the free flag after the processor lowers its bit.

// File: rtl/pktbuf_hs_pkg.sv
package pktbuf_hs_pkg;
  localparam int CW_BITS   = 32;
  localparam int LEN_BITS  = 16;
  localparam int BIT_REL   = 0;
  localparam int BIT_COMMIT = 1;
  localparam int BIT_MODE  = 2;
  localparam int BIT_CLR   = 8;
  localparam int LEN_LSB   = 16;

  typedef enum logic [1:0] {RX_IDLE, RX_AVAIL, RX_RELEASE} rx_state_t;
  typedef enum logic [1:0] {TX_FREE, TX_SEND, TX_HOLD} tx_state_t;
endpackage

// File: rtl/pktbuf_rx_hs.sv
module pktbuf_rx_hs
  import pktbuf_hs_pkg::*;
#(
  parameter int LW = LEN_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          rel,
  input  logic          fill_valid,
  output logic          fill_ready,
  input  logic [LW-1:0] fill_len,
  output logic          avail,
  output logic [LW-1:0] avail_len
);
  rx_state_t st_q, st_d;
  logic [LW-1:0] len_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      RX_IDLE:    if (fill_valid) st_d = RX_AVAIL;
      RX_AVAIL:   if (rel)        st_d = RX_RELEASE;
      RX_RELEASE: if (!rel)       st_d = RX_IDLE;
      default:                    st_d = RX_IDLE;
    endcase
    if (clr) st_d = RX_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      len_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == RX_IDLE && fill_valid && !clr) len_q <= fill_len;
    end
  end

  assign fill_ready = (st_q == RX_IDLE) && !clr;
  assign avail      = (st_q == RX_AVAIL);
  assign avail_len  = avail ? len_q : '0;

  AST_RX_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ready |-> !avail); // R5
  AST_RX_REL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (avail && rel) |=> !avail); // R4
  AST_RX_LEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (avail && !rel && !clr) |=> $stable(avail_len)); // R3
  AST_RX_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !avail); // R9
endmodule

// File: rtl/pktbuf_tx_hs.sv
module pktbuf_tx_hs
  import pktbuf_hs_pkg::*;
#(
  parameter int LW = LEN_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          commit,
  input  logic [LW-1:0] commit_len,
  output logic          free,
  output logic          send_valid,
  input  logic          send_ready,
  output logic [LW-1:0] send_len
);
  tx_state_t st_q, st_d;
  logic [LW-1:0] len_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      TX_FREE: if (commit)     st_d = TX_SEND;
      TX_SEND: if (send_ready) st_d = commit ? TX_HOLD : TX_FREE;
      TX_HOLD: if (!commit)    st_d = TX_FREE;
      default:                 st_d = TX_FREE;
    endcase
    if (clr) st_d = TX_FREE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= TX_FREE;
      len_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == TX_FREE && commit && !clr) len_q <= commit_len;
    end
  end

  assign free       = (st_q == TX_FREE);
  assign send_valid = (st_q == TX_SEND);
  assign send_len   = len_q;

  AST_TX_COMMIT_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (free && commit && !clr) |=> (send_valid && !free)); // R6
  AST_TX_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (send_valid && !send_ready && !clr) |=> (send_valid && $stable(send_len))); // R7
  AST_TX_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (!free && !send_valid && commit && !clr) |=> !free); // R8
  AST_TX_CLR_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (free && !send_valid)); // R9
endmodule

// File: rtl/pktbuf_hs_ctrl.sv
module pktbuf_hs_ctrl
  import pktbuf_hs_pkg::*;
#(
  parameter int CW = CW_BITS,
  parameter int LW = LEN_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] ctrl_word,
  output logic [CW-1:0] status_word,
  input  logic          fill_valid,
  output logic          fill_ready,
  input  logic [LW-1:0] fill_len,
  output logic          send_valid,
  input  logic          send_ready,
  output logic [LW-1:0] send_len,
  output logic          route_master
);
  localparam int LEN_MSB = LEN_LSB + LW - 1;

  logic          clr;
  logic          rx_avail, tx_free;
  logic [LW-1:0] rx_len;

  assign clr          = ctrl_word[BIT_CLR];
  assign route_master = ctrl_word[BIT_MODE];

  pktbuf_rx_hs #(.LW(LW)) rx_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .rel        (ctrl_word[BIT_REL]),
    .fill_valid (fill_valid),
    .fill_ready (fill_ready),
    .fill_len   (fill_len),
    .avail      (rx_avail),
    .avail_len  (rx_len)
  );

  pktbuf_tx_hs #(.LW(LW)) tx_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .commit     (ctrl_word[BIT_COMMIT]),
    .commit_len (ctrl_word[LEN_MSB:LEN_LSB]),
    .free       (tx_free),
    .send_valid (send_valid),
    .send_ready (send_ready),
    .send_len   (send_len)
  );

  always_comb begin
    status_word                  = '0;
    status_word[BIT_REL]         = rx_avail;
    status_word[BIT_COMMIT]      = tx_free;
    status_word[LEN_MSB:LEN_LSB] = rx_len;
  end

  AST_FREE_XOR_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    !(status_word[BIT_COMMIT] && send_valid)); // R6
endmodule

// File: tb/pktbuf_hs_ctrl_tb.sv
module pktbuf_hs_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ctrl_word;
  logic [31:0] status_word;
  logic        fill_valid, fill_ready, send_valid, send_ready, route_master;
  logic [15:0] fill_len, send_len;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pktbuf_hs_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .status_word(status_word),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_len(fill_len),
    .send_valid(send_valid), .send_ready(send_ready), .send_len(send_len),
    .route_master(route_master)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input longint act, input longint exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic rx_case(input logic [15:0] len, input int hold);
    fill_valid = 1'b1; fill_len = len;
    chk_eq("R2 ready before fill", fill_ready, 1);
    tick();
    chk_eq("R2 avail", status_word[0], 1);
    chk_eq("R2 len", status_word[31:16], len);
    fill_len = ~len;
    for (int i = 0; i < 2; i++) begin
      tick();
      chk_eq("R5 ready low", fill_ready, 0);
      chk_eq("R3 len stable", status_word[31:16], len);
    end
    fill_valid = 1'b0;
    ctrl_word[0] = 1'b1;
    tick();
    chk_eq("R4 avail drop", status_word[0], 0);
    chk_eq("R3 len zero", status_word[31:16], 0);
    fill_valid = 1'b1;
    for (int i = 0; i < hold; i++) begin
      tick();
      chk_eq("R4 ready held low", fill_ready, 0);
      chk_eq("R5 fill ignored", status_word[0], 0);
    end
    fill_valid = 1'b0;
    ctrl_word[0] = 1'b0;
    tick();
    chk_eq("R4 ready back", fill_ready, 1);
  endtask

  task automatic tx_case(input logic [15:0] len, input int stall, input bit early_drop);
    chk_eq("R6 free before", status_word[1], 1);
    ctrl_word[31:16] = len; ctrl_word[1] = 1'b1;
    tick();
    chk_eq("R6 free drop", status_word[1], 0);
    chk_eq("R6 valid", send_valid, 1);
    chk_eq("R6 len", send_len, len);
    ctrl_word[31:16] = len ^ 16'h5a5a;
    if (early_drop) ctrl_word[1] = 1'b0;
    for (int i = 0; i < stall; i++) begin
      tick();
      chk_eq("R7 valid held", send_valid, 1);
      chk_eq("R11 len held", send_len, len);
    end
    send_ready = 1'b1;
    tick();
    send_ready = 1'b0;
    chk_eq("R7 valid drop", send_valid, 0);
    if (early_drop) begin
      chk_eq("R8 immediate free", status_word[1], 1);
    end else begin
      tick();
      chk_eq("R8 no rearm", status_word[1], 0);
      ctrl_word[1] = 1'b0;
      tick();
      chk_eq("R8 rearm", status_word[1], 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctrl_word = '0; fill_valid = 1'b0; fill_len = '0; send_ready = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk_eq("R1 avail", status_word[0], 0);
    chk_eq("R1 free", status_word[1], 1);
    chk_eq("R1 fill_ready", fill_ready, 1);
    chk_eq("R1 send_valid", send_valid, 0);

    for (int k = 0; k < 8; k++) begin
      rx_case(16'((k * 16'h1357) ^ (16'h1 << (k * 2))), k % 4);
    end
    for (int k = 0; k < 8; k++) begin
      for (int s = 0; s < 4; s++) begin
        tx_case(16'(16'hffff - k * 16'h2111 + s), s, k[0]);
      end
    end

    // R10 mode passthrough
    for (int m = 0; m < 2; m++) begin
      ctrl_word[2] = m[0];
      #1;
      chk_eq("R10 mode", route_master, m);
    end
    ctrl_word[2] = 1'b0;

    // R9 clear flushes both sides
    fill_valid = 1'b1; fill_len = 16'h00a5;
    tick();
    fill_valid = 1'b0;
    ctrl_word[31:16] = 16'h0042; ctrl_word[1] = 1'b1;
    tick();
    chk_eq("R9 pre avail", status_word[0], 1);
    chk_eq("R9 pre send", send_valid, 1);
    ctrl_word[8] = 1'b1; ctrl_word[1] = 1'b0; fill_valid = 1'b1;
    #1;
    chk_eq("R9 ready low in clear", fill_ready, 0);
    tick();
    chk_eq("R9 avail cleared", status_word[0], 0);
    chk_eq("R9 free set", status_word[1], 1);
    chk_eq("R9 send cleared", send_valid, 0);
    ctrl_word[1] = 1'b1;
    tick();
    chk_eq("R9 fill ignored", status_word[0], 0);
    chk_eq("R9 commit ignored", send_valid, 0);
    ctrl_word[1] = 1'b0; fill_valid = 1'b0; ctrl_word[8] = 1'b0;
    tick();
    chk_eq("R9 ready after clear", fill_ready, 1);
    chk_eq("R9 free after clear", status_word[1], 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule